// File: doc/BRIEF.md
# PCI Interrupt Line Router with SCI Merge

This block collects the eight level-sensitive PCI interrupt request lines (indexed 0 to 7, named A to H) and the power-management SCI level, and drives two registered output buses: 16 lines towards a legacy PIC and 24 lines towards an APIC. Towards the PIC, each request line goes through a programmable routing byte that names a PIC line or switches the request off. Towards the APIC, request line n always lands on line 16+n, so request lines never share an APIC input. The SCI goes to one selectable target and is ORed into whichever bus lines that target reaches.

A byte-wide register port holds the eight routing bytes (0 to 3 in one group, 4 to 7 in a second group), one ACPI control byte with the SCI target select, and one pair of mapping bytes per device slot. A combinational lookup port returns the request line index for a given slot and INTx pin. The interrupt controllers, PCI configuration cycles and power-management timers are outside the block.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads 0x80, the ACPI control byte reads 0x00, and both output buses are all zero.
- R2: Routing byte n sits at address n (0x00 to 0x07). Bit 7 is the disable flag and bits 3:0 name the PIC line; a request line whose disable flag is set never reaches the PIC bus. Every bit written to a routing byte or to the ACPI control byte reads back unchanged.
- R3: Each PIC line is the OR of the levels of all enabled request lines whose routing field names it, and it changes on the first clock edge after the input or routing byte changes.
- R4: APIC line 16+n follows request line n one clock later, whatever its routing byte holds; APIC lines 0 to 15 receive nothing from request lines.
- R5: Bits 2:0 of the ACPI control byte (address 0x08) select the SCI target: 0 gives IRQ 9, 1 gives IRQ 10, 2 gives IRQ 11, 4 gives IRQ 20, 5 gives IRQ 21, and 3, 6 or 7 disconnect the SCI. The SCI level is ORed into the APIC line of its target and, when the target is below 16, into the PIC line of the same number.
- R6: Holding the SCI input at its present level leaves both output buses unchanged.
- R7: Slot s has mapping bytes at 0x40+2s (low) and 0x41+2s (high); in each byte bits 2:0 hold the first pin and bits 6:4 the second (low byte INTA, INTB; high byte INTC, INTD), other bits read zero. After reset pin p of slot s maps to request line ((s+p) mod 4)+4, and the lookup port returns the stored value for the given slot and pin.
- R8: Slot 30 always maps pin p to request line 4+p; its mapping bytes read zero and writes to them are ignored.
- R9: Addresses 0x09 to 0x3F read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pirq_lvl | input | 8 | Request line levels, bit n is line n |
| sci_lvl | input | 1 | Power-management SCI level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| map_slot | input | 5 | Lookup slot number |
| map_pin | input | 2 | Lookup INTx pin, 0 is INTA |
| map_pirq | output | 3 | Request line index for the lookup slot and pin |
| pic_irq | output | 16 | PIC bus lines |
| apic_irq | output | 24 | APIC bus lines |

## Verification
Both output buses sit one register after the request inputs, the SCI input and the routing state, so a change driven just after a falling edge shows on the buses at the next falling edge; a register write lands at one rising edge and its effect on the buses shows one edge after that. The bench drives inputs at falling edges and checks buses after two falling edges for random traffic, and after exactly one for the directed latency case, where it also confirms the value has not moved before that edge. Register reads and the slot lookup are combinational and are sampled a short delay after the address is set.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int NUM_PIRQ   = 8;
  localparam int PIC_LINES  = 16;
  localparam int APIC_LINES = 24;
  localparam int NUM_SLOTS  = 32;
  localparam int FIXED_SLOT = 30;
  localparam int NUM_PINS   = 4;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int GSI_W      = $clog2(APIC_LINES);

  localparam logic [DATA_W-1:0] ROUTE_RST = 8'h80;
  localparam logic [DATA_W-1:0] ACPI_RST  = 8'h00;

  typedef struct packed {
    logic             ok;
    logic [GSI_W-1:0] irq;
  } sci_tgt_t;

  // Decode of the SCI target select field
  function automatic sci_tgt_t sci_target(input logic [2:0] sel);
    sci_tgt_t t;
    t.ok = 1'b1;
    unique case (sel)
      3'd0:    t.irq = GSI_W'(9);
      3'd1:    t.irq = GSI_W'(10);
      3'd2:    t.irq = GSI_W'(11);
      3'd4:    t.irq = GSI_W'(20);
      3'd5:    t.irq = GSI_W'(21);
      default: begin t.ok = 1'b0; t.irq = '0; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int NPIRQ = NUM_PIRQ,
  parameter int DW    = DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPIRQ-1:0]          route_we,
  input  logic                      acpi_we,
  input  logic [DW-1:0]             wdata,
  output logic [NPIRQ-1:0][DW-1:0]  route_q,
  output logic [DW-1:0]             acpi_q
);

  logic [NPIRQ-1:0][DW-1:0] route_d;
  logic [DW-1:0]            acpi_d;

  always_comb begin
    route_d = route_q;
    for (int i = 0; i < NPIRQ; i++) begin
      if (route_we[i]) route_d[i] = wdata;
    end
    acpi_d = acpi_we ? wdata : acpi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIRQ; i++) route_q[i] <= ROUTE_RST;
      acpi_q <= ACPI_RST;
    end else begin
      route_q <= route_d;
      acpi_q  <= acpi_d;
    end
  end

  AST_ONE_ROUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(route_we) && !(acpi_we && |route_we)); // R2

endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map
  import pirq_pkg::*;
#(
  parameter int NSLOT  = NUM_SLOTS,
  parameter int FIXED  = FIXED_SLOT,
  parameter int NPIN   = NUM_PINS,
  parameter int NPIRQ  = NUM_PIRQ,
  parameter int DW     = DATA_W,
  localparam int SLOT_W  = $clog2(NSLOT),
  localparam int PIN_W   = $clog2(NPIN),
  localparam int PIRQ_W  = $clog2(NPIRQ),
  localparam int FIELD_W = DW / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic              whi,
  input  logic [DW-1:0]     wdata,
  input  logic [SLOT_W-1:0] rslot,
  input  logic              rhi,
  output logic [DW-1:0]     rdata,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [PIN_W-1:0]  lk_pin,
  output logic [PIRQ_W-1:0] lk_pirq
);

  localparam int HALF = NPIRQ / 2;

  logic [NPIN-1:0][PIRQ_W-1:0] map_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s == FIXED) begin : g_fixed
      // Hard-wired: pin p to the upper request group, in order
      for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign map_q[s][p] = PIRQ_W'(HALF + p);
      end
    end else begin : g_prog
      logic [NPIN-1:0][PIRQ_W-1:0] map_d;
      logic                        sel;
      assign sel = we && (wslot == SLOT_W'(s));

      always_comb begin
        map_d = map_q[s];
        if (sel) begin
          map_d[{whi, 1'b0}] = wdata[PIRQ_W-1:0];
          map_d[{whi, 1'b1}] = wdata[FIELD_W +: PIRQ_W];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int p = 0; p < NPIN; p++) map_q[s][p] <= PIRQ_W'(((s + p) % HALF) + HALF);
        end else begin
          map_q[s] <= map_d;
        end
      end
    end
  end

  always_comb begin
    if (rslot == SLOT_W'(FIXED)) begin
      rdata = '0;
    end else begin
      rdata = {{(FIELD_W-PIRQ_W){1'b0}}, map_q[rslot][{rhi, 1'b1}],
               {(FIELD_W-PIRQ_W){1'b0}}, map_q[rslot][{rhi, 1'b0}]};
    end
  end

  assign lk_pirq = map_q[lk_slot][lk_pin];

  AST_FIXED_SLOT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot == SLOT_W'(FIXED)) |-> (lk_pirq == PIRQ_W'(HALF + int'(lk_pin)))); // R8

endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge
  import pirq_pkg::*;
#(
  parameter int NPIRQ = NUM_PIRQ,
  parameter int NPIC  = PIC_LINES,
  parameter int NAPIC = APIC_LINES,
  parameter int DW    = DATA_W,
  localparam int PIC_W = $clog2(NPIC),
  localparam int DIS_BIT = DW - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPIRQ-1:0]          pirq_lvl,
  input  logic                      sci_lvl,
  input  logic [NPIRQ-1:0][DW-1:0]  route_q,
  input  logic [DW-1:0]             acpi_q,
  output logic [NPIC-1:0]           pic_q,
  output logic [NAPIC-1:0]          apic_q
);

  logic [NPIC-1:0]  pic_d;
  logic [NAPIC-1:0] apic_d;
  logic [NPIRQ-1:0] dis_vec;
  sci_tgt_t         sci_t;

  assign sci_t = sci_target(acpi_q[2:0]);

  always_comb begin
    pic_d  = '0;
    apic_d = '0;
    for (int p = 0; p < NPIRQ; p++) begin
      dis_vec[p] = route_q[p][DIS_BIT];
      if (!route_q[p][DIS_BIT] && pirq_lvl[p]) pic_d[route_q[p][PIC_W-1:0]] = 1'b1;
      apic_d[NPIC + p] = pirq_lvl[p];
    end
    if (sci_t.ok && sci_lvl) begin
      apic_d[sci_t.irq] = 1'b1;
      if (int'(sci_t.irq) < NPIC) pic_d[sci_t.irq[PIC_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pic_q  <= '0;
      apic_q <= '0;
    end else begin
      pic_q  <= pic_d;
      apic_q <= apic_d;
    end
  end

  AST_APIC_TRACKS_PIRQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((apic_q[NPIC +: NPIRQ] & $past(pirq_lvl)) == $past(pirq_lvl))); // R4

  AST_APIC_LOW_SCI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(apic_q[NPIC-1:0]) <= 1); // R4

  AST_PIC_QUIET_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (&dis_vec && !sci_lvl) |=> (pic_q == '0)); // R2

  AST_SCI_REACHES_APIC: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_lvl && sci_t.ok) |=> apic_q[$past(sci_t.irq)]); // R5

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NPIRQ = NUM_PIRQ,
  parameter int NPIC  = PIC_LINES,
  parameter int NAPIC = APIC_LINES,
  parameter int NSLOT = NUM_SLOTS,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int PIN_W  = $clog2(NUM_PINS),
  localparam int PIRQ_W = $clog2(NPIRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIRQ-1:0]  pirq_lvl,
  input  logic              sci_lvl,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [SLOT_W-1:0] map_slot,
  input  logic [PIN_W-1:0]  map_pin,
  output logic [PIRQ_W-1:0] map_pirq,
  output logic [NPIC-1:0]   pic_irq,
  output logic [NAPIC-1:0]  apic_irq
);

  localparam logic [AW-1:0] ACPI_ADDR = AW'(NPIRQ);

  logic                     is_map, is_route, is_acpi;
  logic [NPIRQ-1:0]         route_we;
  logic                     acpi_we, map_we;
  logic [NPIRQ-1:0][DW-1:0] route_q;
  logic [DW-1:0]            acpi_q, map_rdata;
  logic [SLOT_W-1:0]        a_slot;
  logic                     a_hi;

  assign is_map   = reg_addr[AW-1];
  assign is_route = (reg_addr < AW'(NPIRQ));
  assign is_acpi  = (reg_addr == ACPI_ADDR);
  assign a_slot   = reg_addr[SLOT_W:1];
  assign a_hi     = reg_addr[0];
  assign acpi_we  = reg_we && is_acpi;
  assign map_we   = reg_we && is_map;

  always_comb begin
    route_we = '0;
    if (reg_we && is_route) route_we[reg_addr[PIRQ_W-1:0]] = 1'b1;
  end

  pirq_route_regs #(.NPIRQ(NPIRQ), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .route_we(route_we), .acpi_we(acpi_we),
    .wdata(reg_wdata), .route_q(route_q), .acpi_q(acpi_q)
  );

  pirq_slot_map #(.NSLOT(NSLOT), .NPIRQ(NPIRQ), .DW(DW)) u_map (
    .clk(clk), .rst_n(rst_n), .we(map_we), .wslot(a_slot), .whi(a_hi),
    .wdata(reg_wdata), .rslot(a_slot), .rhi(a_hi), .rdata(map_rdata),
    .lk_slot(map_slot), .lk_pin(map_pin), .lk_pirq(map_pirq)
  );

  pirq_irq_merge #(.NPIRQ(NPIRQ), .NPIC(NPIC), .NAPIC(NAPIC), .DW(DW)) u_merge (
    .clk(clk), .rst_n(rst_n), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
    .route_q(route_q), .acpi_q(acpi_q), .pic_q(pic_irq), .apic_q(apic_irq)
  );

  always_comb begin
    if (is_map)        reg_rdata = map_rdata;
    else if (is_route) reg_rdata = route_q[reg_addr[PIRQ_W-1:0]];
    else if (is_acpi)  reg_rdata = acpi_q;
    else               reg_rdata = '0;
  end

endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pirq_lvl = '0;
  logic        sci_lvl = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [4:0]  map_slot = '0;
  logic [1:0]  map_pin = '0;
  logic [2:0]  map_pirq;
  logic [15:0] pic_irq;
  logic [23:0] apic_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_route [8];
  logic [7:0] m_acpi;
  int         m_map [32][4];

  always #2.5 clk = ~clk;

  pirq_router i_pirq_router (
    .clk(clk), .rst_n(rst_n), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .map_slot(map_slot), .map_pin(map_pin), .map_pirq(map_pirq),
    .pic_irq(pic_irq), .apic_irq(apic_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sci_gsi();
    case (m_acpi[2:0])
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd4: return 20;
      3'd5: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] exp_pic();
    logic [15:0] v = '0;
    int g = sci_gsi();
    for (int p = 0; p < 8; p++)
      if (!m_route[p][7] && pirq_lvl[p]) v[m_route[p][3:0]] = 1'b1;
    if (sci_lvl && g >= 0 && g < 16) v[g] = 1'b1;
    return v;
  endfunction

  function automatic logic [23:0] exp_apic();
    logic [23:0] v = '0;
    int g = sci_gsi();
    v[23:16] = pirq_lvl;
    if (sci_lvl && g >= 0) v[g] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] exp_map_rd(input int s, input int h);
    if (s == 30) return 8'h00;
    return {1'b0, 3'(m_map[s][2*h+1]), 1'b0, 3'(m_map[s][2*h])};
  endfunction

  function automatic int exp_lookup(input int s, input int p);
    if (s == 30) return 4 + p;
    return m_map[s][p];
  endfunction

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 7'd8) m_route[a[2:0]] = d;
    else if (a == 7'd8) m_acpi = d;
    else if (a[6] && a[5:1] != 5'd30) begin
      m_map[a[5:1]][2*a[0]]   = int'(d[2:0]);
      m_map[a[5:1]][2*a[0]+1] = int'(d[6:4]);
    end
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [7:0] e, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata === e, req, 32'(reg_rdata), 32'(e));
  endtask

  task automatic lk_chk(input int s, input int p, input string req);
    map_slot = 5'(s); map_pin = 2'(p);
    #1;
    chk(map_pirq === 3'(exp_lookup(s, p)), req, 32'(map_pirq), 32'(exp_lookup(s, p)));
  endtask

  task automatic bus_chk(input string req);
    chk(pic_irq === exp_pic(), req, 32'(pic_irq), 32'(exp_pic()));
    chk(apic_irq === exp_apic(), req, 32'(apic_irq), 32'(exp_apic()));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pic_keep;
    logic [23:0] apic_keep;
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 8; i++) m_route[i] = 8'h80;
    m_acpi = 8'h00;
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) m_map[s][p] = ((s + p) % 4) + 4;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) rd_chk(7'(i), 8'h80, "R1 route reset");
    rd_chk(7'd8, 8'h00, "R1 acpi reset");
    chk(pic_irq === '0, "R1 pic reset", 32'(pic_irq), 0);
    chk(apic_irq === '0, "R1 apic reset", 32'(apic_irq), 0);
    // R9: unmapped reads
    rd_chk(7'h09, 8'h00, "R9 unmapped");
    rd_chk(7'h3F, 8'h00, "R9 unmapped");
    // R7: default lookup on every slot and pin
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) lk_chk(s, p, "R7 default lookup");
    rd_chk(7'h40 + 7'd2, exp_map_rd(1, 0), "R7 default readback");
    // R8: fixed slot
    wr(7'h7C, 8'h77); wr(7'h7D, 8'h11);
    rd_chk(7'h7C, 8'h00, "R8 fixed slot read");
    rd_chk(7'h7D, 8'h00, "R8 fixed slot read");
    for (int p = 0; p < 4; p++) lk_chk(30, p, "R8 fixed slot lookup");

    // R2: all disabled, requests only reach APIC
    @(negedge clk); pirq_lvl = 8'hFF;
    repeat (2) @(negedge clk);
    bus_chk("R2 disabled lines");
    chk(pic_irq === '0, "R2 pic quiet", 32'(pic_irq), 0);
    chk(apic_irq[15:0] === '0, "R4 low apic empty", 32'(apic_irq[15:0]), 0);
    pirq_lvl = '0;

    // R3: one-cycle latency and sharing
    wr(7'd0, 8'h05); wr(7'd6, 8'h05);
    @(negedge clk);
    pirq_lvl = 8'h01;
    #1 chk(pic_irq[5] === 1'b0, "R3 not before edge", 32'(pic_irq), 0);
    @(negedge clk);
    chk(pic_irq === 16'h0020, "R3 one cycle", 32'(pic_irq), 32'h20);
    chk(apic_irq === 24'h010000, "R4 gsi16", 32'(apic_irq), 32'h010000);
    pirq_lvl = 8'h40;
    @(negedge clk);
    chk(pic_irq === 16'h0020, "R3 shared line", 32'(pic_irq), 32'h20);
    pirq_lvl = 8'h00;
    @(negedge clk);
    chk(pic_irq === 16'h0000, "R3 release", 32'(pic_irq), 0);

    // R5: every select encoding with SCI high
    sci_lvl = 1'b1;
    for (int sel = 0; sel < 8; sel++) begin
      wr(7'd8, 8'(sel));
      repeat (2) @(negedge clk);
      bus_chk("R5 sci select");
    end

    // R6: SCI held at same level
    wr(7'd8, 8'h01);
    repeat (2) @(negedge clk);
    pic_keep = pic_irq; apic_keep = apic_irq;
    for (int k = 0; k < 3; k++) begin
      sci_lvl = 1'b1;
      @(negedge clk);
      chk(pic_irq === pic_keep, "R6 pic steady", 32'(pic_irq), 32'(pic_keep));
      chk(apic_irq === apic_keep, "R6 apic steady", 32'(apic_irq), 32'(apic_keep));
    end
    chk(pic_irq[10] === 1'b1, "R5 sci on pic 10", 32'(pic_irq), 32'h400);

    // Random traffic
    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom_range(0, 5));
      if (r == 0) begin
        int ri = int'($urandom_range(0, 7));
        logic [7:0] d = 8'($urandom);
        wr(7'(ri), d);
        rd_chk(7'(ri), d, "R2 route readback");
      end else if (r == 1) begin
        logic [7:0] d = 8'($urandom);
        wr(7'd8, d);
        rd_chk(7'd8, d, "R2 acpi readback");
      end else if (r == 2) begin
        int s = int'($urandom_range(0, 31));
        int h = int'($urandom_range(0, 1));
        wr(7'h40 + 7'(2*s + h), 8'($urandom));
        rd_chk(7'h40 + 7'(2*s + h), exp_map_rd(s, h), "R7 map readback");
        lk_chk(s, 2*h, "R7 map lookup");
        lk_chk(s, 2*h + 1, "R7 map lookup");
      end
      @(negedge clk);
      pirq_lvl = 8'($urandom);
      sci_lvl  = 1'($urandom);
      repeat (2) @(negedge clk);
      bus_chk("R3 R4 R5 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule